// File: doc/BRIEF.md
# Combined Read-Modify-Write Operation Unit

This unit carries out one of six fused memory-and-accumulator operations for an 8-bit accumulator processor. A caller supplies an operation code, an effective address, the current accumulator, and the incoming carry and overflow flags, then pulses `start`. The unit reads the addressed byte and writes it back unchanged. It then writes back a modified copy, which is the byte shifted, rotated, decremented or incremented. Finally it combines that modified copy with the accumulator through a logic, add, compare or subtract step.

The memory side is a plain synchronous port. A read strobe in one cycle returns its data on `memRdata` in the next cycle. A write strobe stores `memWdata` at `memAddr` on the clock edge that ends the cycle. Address generation, opcode decoding, page-crossing fixups and decimal arithmetic belong to the caller. Flags use the layout {N, V, Z, C} on `flagsOut`, with N in bit 3 and C in bit 0. Only {V, C} enter the unit, on `flagsIn[1:0]`, because N and Z are always recomputed.

Top module: `rmw_combo_unit`

## Requirements
- R1: The bus sequence is fixed. `start` is sampled with a legal code at edge k. `memRd` is high in the cycle after edge k. A write of the byte just read follows in the next cycle. A write of the modified byte follows in the cycle after that. All three accesses use the latched address, and a read and a write are never strobed together.
- R2: Code 0 shifts the byte left with a 0 into bit 0 and bit 7 into C. The new A is A OR the shifted byte. N and Z come from the new A. V keeps its input value.
- R3: Code 1 rotates the byte left with the incoming C into bit 0 and bit 7 into C. The new A is A AND the rotated byte. N and Z come from A, and V is kept.
- R4: Code 2 shifts the byte right with a 0 into bit 7 and bit 0 into C. The new A is A XOR the shifted byte. N and Z come from A, and V is kept.
- R5: Code 3 rotates the byte right with the incoming C into bit 7 and bit 0 into an intermediate carry. The new A is A plus the rotated byte plus that intermediate carry. C is the carry out of bit 7. V is set when A and the rotated byte share a sign and the sum's sign differs.
- R6: Code 4 decrements the byte modulo 256. A is unchanged. N and Z come from (A minus the decremented byte) mod 256. C is set when A is greater than or equal to the decremented byte. V is kept.
- R7: Code 5 increments the byte modulo 256. The new A is A minus that byte minus (1 − C). C is cleared when the difference borrows and set otherwise. V is set when A and the byte differ in sign and the result's sign differs from A. N and Z come from the result.
- R8: `done` is high for exactly one cycle, the cycle after the final write. `accOut`, `byteOut` and `flagsOut` take their new values in that same cycle and hold them until the next operation completes.
- R9: `start` has no effect while `busy` is high. Codes 6 and 7 start nothing: there are no strobes, no `done`, and the outputs do not change.
- R10: After reset, `busy`, `done`, `memRd` and `memWr` are low, and `accOut`, `byteOut` and `flagsOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| opSel | input | 3 | Operation code 0..5 |
| addrIn | input | ADDR_W | Effective address of the operand byte |
| accIn | input | DATA_W | Accumulator value at start |
| flagsIn | input | 2 | Incoming {V, C} |
| memAddr | output | ADDR_W | Memory address |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid the cycle after `memRd` |
| accOut | output | DATA_W | Resulting accumulator |
| byteOut | output | DATA_W | Modified memory byte |
| flagsOut | output | 4 | Resulting {N, V, Z, C} |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each pairing is driven with the sign-boundary bytes 0x00, 0x7F, 0x80 and 0xFF against accumulators at the same boundaries, under both carry values. This separates carry-in placement from carry-out selection and exposes wrap in the decrement and increment steps. The same sweep exercises signed overflow in the add and subtract pairings, because the boundary accumulators sit on both sides of the sign change. A random sweep then covers the remaining data paths. Directed cases pin the cycle of each strobe and the write-back order, and show that restarts during an operation and the two unused codes leave memory and outputs untouched.

// File: rtl/rmw_combo_pkg.sv
package rmw_combo_pkg;

  typedef enum logic [2:0] {
    OP_SHL_OR  = 3'd0,
    OP_ROL_AND = 3'd1,
    OP_SHR_XOR = 3'd2,
    OP_ROR_ADC = 3'd3,
    OP_DEC_CMP = 3'd4,
    OP_INC_SBC = 3'd5
  } rmwOp_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_V = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;
  localparam int FLAG_W = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request inputs
    logic rdStb;    // memory read cycle
    logic wrStb;    // any write cycle
    logic wrMod;    // write carries the modified byte
    logic capture;  // latch returned read data
    logic commit;   // register results
  } ctlStrobe_t;

  function automatic logic opLegal(input logic [2:0] op);
    return op <= 3'd5;
  endfunction

endpackage

// File: rtl/rmw_combo_ctrl.sv
module rmw_combo_ctrl
  import rmw_combo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opValid,
  output ctlStrobe_t strb,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WKEEP, ST_WMOD, ST_FIN
  } state_e;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start && opValid) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WKEEP;
      ST_WKEEP: stateNext = ST_WMOD;
      ST_WMOD:  stateNext = ST_FIN;
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb         = '0;
    strb.load    = (state == ST_IDLE) && start && opValid;
    strb.rdStb   = (state == ST_READ);
    strb.wrStb   = (state == ST_WKEEP) || (state == ST_WMOD);
    strb.wrMod   = (state == ST_WMOD);
    strb.capture = (state == ST_WKEEP);
    strb.commit  = (state == ST_WMOD);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  p_rd_then_keep_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStb |=> (strb.wrStb && !strb.wrMod));
  p_keep_then_mod_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && !strb.wrMod) |=> strb.wrMod);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_busy_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !strb.rdStb);

endmodule

// File: rtl/rmw_combo_alu.sv
module rmw_combo_alu
  import rmw_combo_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rmwOp_e              op,
  input  logic [DATA_W-1:0]   acc,
  input  logic [1:0]          flagsVC,
  input  logic [DATA_W-1:0]   operand,
  output logic [DATA_W-1:0]   modByte,
  output logic [DATA_W-1:0]   accNew,
  output logic [FLAG_W-1:0]   flagsNew
);

  localparam int MSB = DATA_W - 1;

  logic              carryIn, carryMid, carryOut, ovf;
  logic [DATA_W-1:0] flagSrc;
  logic [DATA_W:0]   wide;

  assign carryIn = flagsVC[0];

  // first half: memory byte transform
  always_comb begin
    carryMid = carryIn;
    unique case (op)
      OP_SHL_OR:  begin modByte = {operand[MSB-1:0], 1'b0};    carryMid = operand[MSB]; end
      OP_ROL_AND: begin modByte = {operand[MSB-1:0], carryIn}; carryMid = operand[MSB]; end
      OP_SHR_XOR: begin modByte = {1'b0, operand[MSB:1]};      carryMid = operand[0];   end
      OP_ROR_ADC: begin modByte = {carryIn, operand[MSB:1]};   carryMid = operand[0];   end
      OP_DEC_CMP: modByte = operand - DATA_W'(1);
      OP_INC_SBC: modByte = operand + DATA_W'(1);
      default:    modByte = operand;
    endcase
  end

  // second half: accumulator step on the modified byte
  always_comb begin
    wide     = '0;
    accNew   = acc;
    carryOut = carryMid;
    ovf      = flagsVC[1];
    unique case (op)
      OP_SHL_OR:  accNew = acc | modByte;
      OP_ROL_AND: accNew = acc & modByte;
      OP_SHR_XOR: accNew = acc ^ modByte;
      OP_ROR_ADC: begin
        wide     = {1'b0, acc} + {1'b0, modByte} + {{DATA_W{1'b0}}, carryMid};
        accNew   = wide[MSB:0];
        carryOut = wide[DATA_W];
        ovf      = ~(acc[MSB] ^ modByte[MSB]) & (acc[MSB] ^ wide[MSB]);
      end
      OP_DEC_CMP: begin
        wide     = {1'b0, acc} - {1'b0, modByte};
        carryOut = ~wide[DATA_W];
      end
      OP_INC_SBC: begin
        wide     = {1'b0, acc} - {1'b0, modByte} - {{DATA_W{1'b0}}, ~carryIn};
        accNew   = wide[MSB:0];
        carryOut = ~wide[DATA_W];
        ovf      = (acc[MSB] ^ modByte[MSB]) & (acc[MSB] ^ wide[MSB]);
      end
      default: ;
    endcase
  end

  assign flagSrc = (op == OP_DEC_CMP) ? wide[MSB:0] : accNew;

  always_comb begin
    flagsNew         = '0;
    flagsNew[FLAG_N] = flagSrc[MSB];
    flagsNew[FLAG_V] = ovf;
    flagsNew[FLAG_Z] = (flagSrc == '0);
    flagsNew[FLAG_C] = carryOut;
  end

endmodule

// File: rtl/rmw_combo_dp.sv
module rmw_combo_dp
  import rmw_combo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [2:0]        opIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [1:0]        flagsIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] byteOut,
  output logic [FLAG_W-1:0] flagsOut
);

  rmwOp_e            opR;
  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] accR, byteR, modByte, accNew;
  logic [1:0]        flgR;
  logic [FLAG_W-1:0] flagsNew;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR   <= OP_SHL_OR;
      addrR <= '0;
      accR  <= '0;
      flgR  <= '0;
      byteR <= '0;
    end else begin
      if (strb.load) begin
        opR   <= rmwOp_e'(opIn);
        addrR <= addrIn;
        accR  <= accIn;
        flgR  <= flagsIn;
      end
      if (strb.capture) byteR <= memRdata;
    end
  end

  rmw_combo_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (opR),
    .acc      (accR),
    .flagsVC  (flgR),
    .operand  (byteR),
    .modByte  (modByte),
    .accNew   (accNew),
    .flagsNew (flagsNew)
  );

  assign memAddr  = addrR;
  assign memRd    = strb.rdStb;
  assign memWr    = strb.wrStb;
  assign memWdata = strb.wrMod ? modByte : memRdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accOut   <= '0;
      byteOut  <= '0;
      flagsOut <= '0;
    end else if (strb.commit) begin
      accOut   <= accNew;
      byteOut  <= modByte;
      flagsOut <= flagsNew;
    end
  end

  p_rw_exclusive_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));
  p_same_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && $past(memWr)) |-> (memAddr == $past(memAddr)));
  p_cmp_keeps_acc_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.commit) && $past(opR) == OP_DEC_CMP) |-> (accOut == $past(accR)));
  p_logic_keeps_v_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.commit) && $past(opR) != OP_ROR_ADC && $past(opR) != OP_INC_SBC)
      |-> (flagsOut[FLAG_V] == $past(flgR[1])));
  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.commit) |-> $stable(accOut));

endmodule

// File: rtl/rmw_combo_unit.sv
module rmw_combo_unit
  import rmw_combo_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] accIn,
  input  logic [1:0]        flagsIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] byteOut,
  output logic [3:0]        flagsOut,
  output logic              busy,
  output logic              done
);

  ctlStrobe_t strb;
  logic       opValid;

  assign opValid = opLegal(opSel);

  rmw_combo_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opValid (opValid),
    .strb    (strb),
    .busy    (busy),
    .done    (done)
  );

  rmw_combo_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opIn     (opSel),
    .addrIn   (addrIn),
    .accIn    (accIn),
    .flagsIn  (flagsIn),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memRd    (memRd),
    .memWr    (memWr),
    .memWdata (memWdata),
    .accOut   (accOut),
    .byteOut  (byteOut),
    .flagsOut (flagsOut)
  );

  p_bad_op_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !opValid) |=> !busy);

endmodule

// File: tb/tb_rmw_combo_unit.sv
module tb_rmw_combo_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [15:0] addrIn = '0;
  logic [7:0]  accIn = '0;
  logic [1:0]  flagsIn = '0;
  logic [15:0] memAddr;
  logic        memRd, memWr, busy, done;
  logic [7:0]  memWdata, accOut, byteOut;
  logic [7:0]  memRdata = '0;
  logic [3:0]  flagsOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  int rdCnt = 0, wrCnt = 0, doneCnt = 0;
  logic [7:0]  wPrev = '0, wLast = '0;
  logic [15:0] wAddrPrev = '0, wAddrLast = '0;
  logic [7:0]  mem [0:255];

  rmw_combo_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .addrIn(addrIn),
    .accIn(accIn), .flagsIn(flagsIn), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata), .accOut(accOut),
    .byteOut(byteOut), .flagsOut(flagsOut), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // synchronous memory model and bus log
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memRd) begin
      memRdata <= mem[memAddr[7:0]];
      rdCnt <= rdCnt + 1;
    end
    if (memWr) begin
      mem[memAddr[7:0]] <= memWdata;
      wPrev <= wLast; wLast <= memWdata;
      wAddrPrev <= wAddrLast; wAddrLast <= memAddr;
      wrCnt <= wrCnt + 1;
    end
    if (done) doneCnt <= doneCnt + 1;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tagFor(input int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  // returns {acc, modified byte, flags N V Z C}
  function automatic logic [19:0] refCalc(input int op, input int a,
                                          input int vIn, input int cIn, input int b);
    int m = 0, c = 0, nA = a, res = 0, v = vIn, s = 0;
    case (op)
      0: begin m = (b * 2) % 256; c = b / 128; nA = a | m; res = nA; end
      1: begin m = (b * 2 + cIn) % 256; c = b / 128; nA = a & m; res = nA; end
      2: begin m = b / 2; c = b % 2; nA = a ^ m; res = nA; end
      3: begin
        m = b / 2 + cIn * 128; s = a + m + (b % 2);
        nA = s % 256; c = (s > 255) ? 1 : 0; res = nA;
        v = ((a >= 128) == (m >= 128) && (nA >= 128) != (a >= 128)) ? 1 : 0;
      end
      4: begin
        m = (b + 255) % 256; c = (a >= m) ? 1 : 0;
        res = (a - m + 256) % 256; nA = a;
      end
      default: begin
        m = (b + 1) % 256; s = a - m - (1 - cIn);
        nA = (s + 512) % 256; c = (s >= 0) ? 1 : 0; res = nA;
        v = ((a >= 128) != (m >= 128) && (nA >= 128) != (a >= 128)) ? 1 : 0;
      end
    endcase
    return {nA[7:0], m[7:0], res >= 128, v[0], res == 0, c[0]};
  endfunction

  task automatic runOp(input int op, input logic [15:0] addr, input logic [7:0] a,
                       input logic [1:0] f, input logic [7:0] b);
    logic [19:0] exp;
    int rd0, wr0, waited;
    string tg = tagFor(op);
    mem[addr[7:0]] = b;
    rd0 = rdCnt; wr0 = wrCnt;
    @(negedge clk);
    opSel = op[2:0]; addrIn = addr; accIn = a; flagsIn = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 12) begin @(negedge clk); waited++; end
    exp = refCalc(op, a, f[1], f[0], b);
    check(done, "R8", "done seen", done, 1);
    check(accOut == exp[19:12], tg, "accOut", accOut, exp[19:12]);
    check(byteOut == exp[11:4], tg, "byteOut", byteOut, exp[11:4]);
    check(flagsOut == exp[3:0], tg, "flagsOut", flagsOut, exp[3:0]);
    check(mem[addr[7:0]] == exp[11:4], "R1", "memory byte", mem[addr[7:0]], exp[11:4]);
    check(wrCnt - wr0 == 2 && rdCnt - rd0 == 1, "R1", "access count",
          (wrCnt - wr0) * 16 + (rdCnt - rd0), 2 * 16 + 1);
    check(wPrev == b && wLast == exp[11:4], "R1", "write order",
          {wPrev, wLast}, {b, exp[11:4]});
    check(wAddrPrev == addr && wAddrLast == addr, "R1", "write address", wAddrLast, addr);
    @(negedge clk);
    check(!done, "R8", "done single cycle", done, 0);
  endtask

  task automatic testReset();
    check(!busy && !done && !memRd && !memWr, "R10", "control idle",
          {busy, done, memRd, memWr}, 0);
    check(accOut == 0 && byteOut == 0 && flagsOut == 0, "R10", "outputs zero",
          {accOut, byteOut, flagsOut}, 0);
  endtask

  task automatic testPairing(input int op);
    logic [7:0] edges [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int c = 0; c < 2; c++)
          runOp(op, 16'h0100 + 16'(i * 4 + j), edges[j], {c[0] ^ i[0], c[0]}, edges[i]);
  endtask

  task automatic testRandom();
    for (int k = 0; k < 240; k++)
      runOp(k % 6, 16'($urandom_range(0, 255)), 8'($urandom), 2'($urandom), 8'($urandom));
  endtask

  task automatic testTiming();
    mem[8'h42] = 8'h81;
    @(negedge clk);
    opSel = 3'd0; addrIn = 16'h0142; accIn = 8'h10; flagsIn = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(memRd && !memWr && memAddr == 16'h0142, "R1", "read cycle", {memRd, memWr}, 2'b10);
    @(negedge clk);
    check(memWr && !memRd && memWdata == 8'h81, "R1", "unchanged write", memWdata, 8'h81);
    @(negedge clk);
    check(memWr && memWdata == 8'h02 && !done, "R1", "modified write", memWdata, 8'h02);
    @(negedge clk);
    check(done && !memWr && accOut == 8'h12 && flagsOut == 4'b0001, "R8", "done and result",
          {done, accOut, flagsOut}, {1'b1, 8'h12, 4'b0001});
    @(negedge clk);
    check(!done && !busy, "R8", "back to idle", {done, busy}, 0);
    repeat (3) @(negedge clk);
    check(accOut == 8'h12 && byteOut == 8'h02, "R8", "outputs held", accOut, 8'h12);
  endtask

  task automatic testBusyRestart();
    int wr0, rd0, dn0;
    mem[8'h20] = 8'h40; mem[8'h30] = 8'h55;
    wr0 = wrCnt; rd0 = rdCnt; dn0 = doneCnt;
    @(negedge clk);
    opSel = 3'd1; addrIn = 16'h0020; accIn = 8'hFF; flagsIn = 2'b01; start = 1'b1;
    @(negedge clk);
    opSel = 3'd5; addrIn = 16'h0030; accIn = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (8) @(negedge clk);
    check(accOut == 8'h81 && byteOut == 8'h81, "R9", "first op result", accOut, 8'h81);
    check(mem[8'h30] == 8'h55, "R9", "restart address untouched", mem[8'h30], 8'h55);
    check(wrCnt - wr0 == 2 && rdCnt - rd0 == 1 && doneCnt - dn0 == 1, "R9",
          "single sequence", (wrCnt - wr0) * 16 + (doneCnt - dn0), 2 * 16 + 1);
  endtask

  task automatic testBadOp();
    int wr0, rd0, dn0;
    logic [7:0] a0, b0;
    logic [3:0] f0;
    wr0 = wrCnt; rd0 = rdCnt; dn0 = doneCnt;
    a0 = accOut; b0 = byteOut; f0 = flagsOut;
    for (int op = 6; op < 8; op++) begin
      @(negedge clk);
      opSel = op[2:0]; addrIn = 16'h0010; accIn = 8'h5A; flagsIn = 2'b11; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!busy && !memRd, "R9", "unused code stays idle", {busy, memRd}, 0);
      repeat (5) @(negedge clk);
    end
    check(wrCnt == wr0 && rdCnt == rd0 && doneCnt == dn0, "R9", "no bus activity",
          wrCnt - wr0 + rdCnt - rd0 + doneCnt - dn0, 0);
    check(accOut == a0 && byteOut == b0 && flagsOut == f0, "R9", "outputs unchanged",
          {accOut, byteOut, flagsOut}, {a0, b0, f0});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTiming();
    for (int op = 0; op < 6; op++) testPairing(op);
    testRandom();
    testBusyRestart();
    testBadOp();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    testsFailed++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule